// File: doc/BRIEF.md
# Clear-on-Read Interrupt Status Register with Event Masking

This block collects single-cycle event pulses from a line interface's transmit and receive paths into an 8-bit sticky status register. A per-bit mask register decides which latched events may raise the interrupt line and the summary bit that feeds a chip-level interrupt collector. The register is read through a simple address, read strobe and write strobe bus. A read returns the register contents and clears every bit in the same access.

A global visibility input selects how masked events are handled. When the input is low, a masked event is dropped. When it is high, a masked event is still latched so software can poll it. In both cases a masked bit is kept away from the interrupt line and the summary bit. An event that coincides with a clearing read is not lost: it shows up in the register after the clear.

Top module: `irq_status_block`

## Requirements
- R1: After synchronous reset the status register is all zero, every mask bit is 1 (masked), `irq_o` and `summary_o` are 0 and `bus_rdata_o` is 0.
- R2: An event pulse on an unmasked implemented bit sets that status bit, and the bit stays set until the status register is read.
- R3: While `latch_masked_i` is 0, an event pulse on a bit whose mask bit is 1 leaves the status register unchanged.
- R4: While `latch_masked_i` is 1, an event pulse on a masked bit sets that status bit, and it can be read back.
- R5: `irq_o` is active high and level-sensitive, and it equals the OR over all bits that are both set in the status register and 0 in the mask register.
- R6: `summary_o` follows the same rule as `irq_o`, so a set but masked status bit never asserts it.
- R7: A read strobe with address `STAT_ADDR` (default 0x69) places the status contents on `bus_rdata_o` in the next cycle and clears every status bit. A read of the mask address returns the mask. Any other read, and any cycle without a read strobe, gives 0.
- R8: An event accepted in the same cycle as a clearing read is absent from that read's data but present in the status register afterwards.
- R9: A write strobe to `STAT_ADDR` has no effect on the status register.
- R10: The mask register at `MASK_ADDR` (default 0x6A) is written from `bus_wdata_i` on a write strobe and reads back the written value. A 1 means masked. It changes on no other access.
- R11: Bit positions are 7 signalling-refill-due, 6 receive overflow, 5 transmit all sent, 4 transmit underrun, 3 transmit block done, 2 line status change, 1 transmit ready. Bit 0 is unimplemented: its event input is ignored and it always reads 0.
- R12: Clearing the mask bit of a status bit already latched under visibility asserts `irq_o` in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | Event pulses, one per status bit |
| latch_masked_i | input | 1 | Global visibility: latch masked events when 1 |
| bus_addr_i | input | ADDR_W | Register address |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt line, active high |
| summary_o | output | 1 | Summary bit for the global interrupt collector |

## Verification
Several rules are checked by assertions on every cycle: set bits stay sticky, a read with no new events leaves the register empty, coincident events survive a clear, bit 0 stays clear, masked events are dropped when visibility is off, the mask changes only on its own write, and no masked bit ever drives the interrupt or summary outputs. Other behaviour can only be shown by the bench scenarios, because it concerns what reaches the bus. These are the exact value returned by a read, the one-cycle read latency, coincident events missing from that read's data, unmasking an already latched bit, and writes to the read-only address having no effect.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

    localparam int REG_W = 8;
    typedef logic [REG_W-1:0] reg_t;

    localparam int BIT_SIG_REFILL = 7;
    localparam int BIT_RX_OVFL    = 6;
    localparam int BIT_TX_DONE    = 5;
    localparam int BIT_TX_UNDER   = 4;
    localparam int BIT_TX_BLOCK   = 3;
    localparam int BIT_LINE_CHG   = 2;
    localparam int BIT_TX_READY   = 1;

    // Implemented bits; bit 0 is unimplemented
    localparam reg_t IMPL_BITS = reg_t'((1 << BIT_SIG_REFILL) | (1 << BIT_RX_OVFL)
                                      | (1 << BIT_TX_DONE)    | (1 << BIT_TX_UNDER)
                                      | (1 << BIT_TX_BLOCK)   | (1 << BIT_LINE_CHG)
                                      | (1 << BIT_TX_READY));

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_MASK = 2'd2
    } sel_e;

    typedef struct packed {
        logic rd;
        logic wr;
        sel_e sel;
    } access_t;

    // Events allowed into the status register this cycle
    function automatic reg_t accept_events(reg_t ev, reg_t mask, logic keep_masked);
        reg_t gate;
        gate = keep_masked ? '1 : ~mask;
        return ev & IMPL_BITS & gate;
    endfunction

    // Bits allowed to reach the interrupt line
    function automatic logic any_pending(reg_t stat, reg_t mask);
        return |(stat & ~mask);
    endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_stat_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'('h69),
    parameter logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'('h6A)
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    output access_t           acc_o
);
    always_comb begin
        acc_o.rd = rd_i;
        acc_o.wr = wr_i;
        if (addr_i == STAT_ADDR)      acc_o.sel = SEL_STAT;
        else if (addr_i == MASK_ADDR) acc_o.sel = SEL_MASK;
        else                          acc_o.sel = SEL_NONE;
    end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_stat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en_i,
    input  reg_t wdata_i,
    output reg_t mask_o
);
    reg_t mask_q;

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '1;
        else if (wr_en_i) mask_q <= wdata_i;
    end

    assign mask_o = mask_q;

    // R10: mask only moves on its own write
    p_mask_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(mask_q));
    p_mask_load_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (mask_q == $past(wdata_i)));
endmodule

// File: rtl/irq_latch.sv
module irq_latch
    import irq_stat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  reg_t set_i,
    input  logic clr_i,
    output reg_t stat_o
);
    reg_t stat_q;

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (IMPL_BITS[b]) begin : g_impl
            always_ff @(posedge clk) begin
                if (rst) stat_q[b] <= 1'b0;
                else     stat_q[b] <= set_i[b] | (stat_q[b] & ~clr_i);
            end
        end else begin : g_rsvd
            assign stat_q[b] = 1'b0;
        end
    end

    assign stat_o = stat_q;

    // R2: set bits stay set unless cleared
    p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
    // R7: a clear with no new events empties the register
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_i && (set_i == '0)) |=> (stat_q == '0));
    // R8: events coinciding with a clear survive it
    p_keep_on_clear_r8: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> ((stat_q & $past(set_i)) == $past(set_i)));
    // R11: unimplemented bit never set
    p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (rst)
        stat_q[0] == 1'b0);
endmodule

// File: rtl/irq_status_block.sv
module irq_status_block
    import irq_stat_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'('h69),
    parameter logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'('h6A)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        evt_i,
    input  logic              latch_masked_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_rd_i,
    input  logic              bus_wr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    output logic              irq_o,
    output logic              summary_o
);
    access_t acc;
    reg_t    mask;
    reg_t    stat;
    reg_t    accepted;
    reg_t    rdata_q;
    logic    clr_stat;
    logic    mask_wr;
    logic    pending;

    irq_bus_decode #(
        .ADDR_W    (ADDR_W),
        .STAT_ADDR (STAT_ADDR),
        .MASK_ADDR (MASK_ADDR)
    ) u_dec (
        .addr_i (bus_addr_i),
        .rd_i   (bus_rd_i),
        .wr_i   (bus_wr_i),
        .acc_o  (acc)
    );

    assign clr_stat = acc.rd && (acc.sel == SEL_STAT);
    assign mask_wr  = acc.wr && (acc.sel == SEL_MASK);
    assign accepted = accept_events(evt_i, mask, latch_masked_i);

    irq_mask_reg u_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (mask_wr),
        .wdata_i (bus_wdata_i),
        .mask_o  (mask)
    );

    irq_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .set_i  (accepted),
        .clr_i  (clr_stat),
        .stat_o (stat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (acc.rd) begin
            unique case (acc.sel)
                SEL_STAT: rdata_q <= stat;
                SEL_MASK: rdata_q <= mask;
                default:  rdata_q <= '0;
            endcase
        end else begin
            rdata_q <= '0;
        end
    end

    assign pending     = any_pending(stat, mask);
    assign irq_o       = pending;
    assign summary_o   = pending;
    assign bus_rdata_o = rdata_q;

    // R3: with visibility off, no masked bit becomes newly set
    p_drop_masked_r3: assert property (@(posedge clk) disable iff (rst)
        !latch_masked_i |=> ((stat & ~$past(stat) & $past(mask)) == '0));
    // R5: the interrupt line is never driven by masked-only status
    p_irq_unmasked_only_r5: assert property (@(posedge clk) disable iff (rst)
        ((stat & ~mask) == '0) |-> !irq_o);
    // R6: summary bit never driven by masked-only status
    p_summary_unmasked_only_r6: assert property (@(posedge clk) disable iff (rst)
        ((stat & ~mask) == '0) |-> !summary_o);
    // R7: read of status clears it unless events arrive
    p_read_data_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_stat && (accepted == '0)) |=> (stat == '0));
endmodule

// File: tb/irq_status_block_tb.sv
module irq_status_block_tb;

    localparam logic [7:0] A_STAT = 8'h69;
    localparam logic [7:0] A_MASK = 8'h6A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] evt = '0;
    logic       vis = 1'b0;
    logic [7:0] addr = '0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    logic       summ;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    string tag   = "R1";

    // reference model state
    logic [7:0] m_stat = '0;
    logic [7:0] m_mask = '1;
    logic [7:0] m_rdata = '0;

    always #2 clk = ~clk;

    irq_status_block u_dut (
        .clk            (clk),
        .rst            (rst),
        .evt_i          (evt),
        .latch_masked_i (vis),
        .bus_addr_i     (addr),
        .bus_rd_i       (rd),
        .bus_wr_i       (wr),
        .bus_wdata_i    (wdata),
        .bus_rdata_o    (rdata),
        .irq_o          (irq),
        .summary_o      (summ)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic [7:0] acc;
        if (rst) begin
            m_stat = '0; m_mask = '1; m_rdata = '0;
        end else begin
            acc = evt & 8'hFE;
            if (!vis) acc = acc & ~m_mask;
            if (rd && addr == A_STAT)      m_rdata = m_stat;
            else if (rd && addr == A_MASK) m_rdata = m_mask;
            else                           m_rdata = '0;
            if (rd && addr == A_STAT) m_stat = '0;
            m_stat = m_stat | acc;
            if (wr && addr == A_MASK) m_mask = wdata;
        end
    endtask

    task automatic compare();
        logic exp_irq;
        exp_irq = |(m_stat & ~m_mask);
        check({tag, " rdata"}, rdata, m_rdata);
        check("R5 irq", {7'd0, irq}, {7'd0, exp_irq});
        check("R6 summary", {7'd0, summ}, {7'd0, exp_irq});
    endtask

    task automatic step(input logic [7:0] e, input logic v, input logic r, input logic w,
                        input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        evt = e; vis = v; rd = r; wr = w; addr = a; wdata = d;
        @(posedge clk);
        #1;
        model_edge();
        compare();
    endtask

    task automatic idle();
        step(8'h00, vis, 1'b0, 1'b0, 8'h00, 8'h00);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] lfsr;
        // R1 reset state
        tag = "R1";
        rst = 1'b1;
        repeat (3) begin
            @(posedge clk); #1; model_edge();
        end
        @(negedge clk); rst = 1'b0;
        compare();
        step(8'h00, 1'b0, 1'b1, 1'b0, A_MASK, 8'h00);
        check("R1 mask reset", rdata, 8'hFF);

        // R3: masked events dropped while visibility off
        tag = "R3";
        step(8'hFE, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        step(8'h00, 1'b0, 1'b1, 1'b0, A_STAT, 8'h00);
        check("R3 masked dropped", rdata, 8'h00);

        // R10: program mask, read back
        tag = "R10";
        step(8'h00, 1'b0, 1'b0, 1'b1, A_MASK, 8'h0F);
        step(8'h00, 1'b0, 1'b1, 1'b0, A_MASK, 8'h00);
        check("R10 mask readback", rdata, 8'h0F);

        // R2: unmasked events sticky; R11 bit 0 ignored
        tag = "R2";
        step(8'hA1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        idle(); idle();
        check("R2 irq held", {7'd0, irq}, 8'h01);
        tag = "R11";
        step(8'h00, 1'b0, 1'b1, 1'b0, A_STAT, 8'h00);
        check("R11 bit0 clear / R7 data", rdata, 8'hA0);
        tag = "R7";
        step(8'h00, 1'b0, 1'b1, 1'b0, A_STAT, 8'h00);
        check("R7 cleared after read", rdata, 8'h00);

        // R4: visibility on latches masked events, no interrupt
        tag = "R4";
        step(8'h06, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        check("R4 masked no irq", {7'd0, irq}, 8'h00);
        check("R6 masked no summary", {7'd0, summ}, 8'h00);

        // R12: unmasking a latched bit raises irq next cycle
        tag = "R12";
        step(8'h00, 1'b1, 1'b0, 1'b1, A_MASK, 8'h0B);
        check("R12 irq after unmask", {7'd0, irq}, 8'h01);
        step(8'h00, 1'b1, 1'b1, 1'b0, A_STAT, 8'h00);
        check("R4 latched readable", rdata, 8'h06);

        // R9: write to status has no effect
        tag = "R9";
        step(8'h00, 1'b0, 1'b0, 1'b1, A_STAT, 8'hFF);
        step(8'h00, 1'b0, 1'b1, 1'b0, A_STAT, 8'h00);
        check("R9 readonly", rdata, 8'h00);

        // R8: event coinciding with read survives
        tag = "R8";
        step(8'h40, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        step(8'h80, 1'b0, 1'b1, 1'b0, A_STAT, 8'h00);
        check("R8 read excludes new", rdata, 8'h40);
        step(8'h00, 1'b0, 1'b1, 1'b0, A_STAT, 8'h00);
        check("R8 kept after clear", rdata, 8'h80);

        // R7: other address reads zero
        tag = "R7";
        step(8'h00, 1'b0, 1'b1, 1'b0, 8'h33, 8'h00);
        check("R7 other addr", rdata, 8'h00);

        // mixed traffic against the model
        tag = "R5";
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            case (lfsr[9:8])
                2'd0, 2'd1: a = A_STAT;
                2'd2:       a = A_MASK;
                default:    a = 8'h10;
            endcase
            step(lfsr[7:0] & {8{lfsr[12]}}, lfsr[13], lfsr[15:14] == 2'b00,
                 lfsr[18:16] == 3'b000, a, lfsr[27:20]);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule